// File: doc/BRIEF.md
# Quad DAC Parallel Register Front End

This block is the digital side of a four-channel, 14-bit digital-to-analog converter. A host writes words over a parallel bus that has an active-low chip select, an active-low write strobe and a 3-bit address. The words land in five data registers: one for each channel and one shared preset word. The block drives a 14-bit code for each channel, a per-channel flag that forces the analog output onto its sense ground, and a one-cycle pulse for each channel whenever that channel's code changes.

The write strobe, chip select and preset-select level are asynchronous to the system clock. Each passes through a two-flop synchroniser. A write is committed on the clock cycle in which the synchronised strobe is first seen high again. A broadcast address loads all four channel registers with one write. A level input makes every channel show the preset word instead of its own register. An asynchronous active-low clear raises all force flags without touching any stored word.

Top module: `quad_dac_frontend`

## Requirements
- R1: A synchronous active-low reset sets all five data registers and all four channel codes to zero, sets the update pulses to zero and leaves the force flags low while clear is high.
- R2: A write takes effect only on a rising edge of `wr_n` while `cs_n` is low. A strobe with `cs_n` held high changes no register.
- R3: Address 0, 1, 2 and 3 load channels A, B, C and D. Channel n's code appears at `chan_code[14n+13:14n]`, and bit 13 of `din` is the MSB.
- R4: Address 4 loads the preset register. While preset select is low, this write changes no channel code.
- R5: Address 7 writes the same word into all four channel registers in one write.
- R6: Writes to address 5 or 6 are ignored and change no register or code.
- R7: While `preset_sel` is high, every channel code equals the preset word. When it returns low, each channel again shows its own register, which the select did not alter.
- R8: While `clr_n` is low, every bit of `sense_gnd` is high, independent of the clock. Codes and registers keep their values, writes still load registers, and `sense_gnd` returns to zero when `clr_n` rises.
- R9: `upd[n]` pulses for exactly one cycle when channel n's code changes, and never when the code does not change.
- R10: A committed write shows at the code outputs within six clock cycles after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low; the data is committed on its rising edge |
| addr | input | 3 | Register address |
| din | input | 14 | Parallel data word, straight binary |
| preset_sel | input | 1 | Level input; when high, all channels show the preset word |
| clr_n | input | 1 | Asynchronous clear, active low; forces the outputs to sense ground |
| chan_code | output | 56 | Four 14-bit channel codes, with channel A in the low bits |
| sense_gnd | output | 4 | Per-channel force-to-sense-ground flag |
| upd | output | 4 | Per-channel one-cycle pulse when a code changes |

## Verification
The hardest case to reach is a code change on some channels but not others. This happens when the preset select toggles while some channel registers already hold the preset value, or when a broadcast write repeats a word that one channel already has. The stimulus first loads a channel with the same word as the preset register, then toggles the select, then broadcasts a word that matches one channel. The scoreboard expects pulses only on the channels whose code actually moved. The clear is driven between clock edges, and a write is made while it is low, to show that the registers keep working under the mask.

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend #(
  parameter int DW   = 14,
  parameter int NCH  = 4,
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  input  logic              preset_sel,
  input  logic              clr_n,
  output logic [NCH*DW-1:0] chan_code,
  output logic [NCH-1:0]    sense_gnd,
  output logic [NCH-1:0]    upd
);
  localparam logic [AW-1:0] PRE_ADDR   = AW'(NCH);
  localparam logic [AW-1:0] BCAST_ADDR = {AW{1'b1}};

  logic [SYNC-1:0] wr_sy, cs_sy, sel_sy;
  logic            wr_d, cs_d;
  logic            wr_s, sel_s, wr_rise;
  logic [NCH:0][DW-1:0]  dreg_q;
  logic [NCH-1:0][DW-1:0] code_q;
  logic [NCH-1:0]         upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sy  <= '1;
      cs_sy  <= '1;
      sel_sy <= '0;
      wr_d   <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      wr_sy  <= {wr_sy[SYNC-2:0], wr_n};
      cs_sy  <= {cs_sy[SYNC-2:0], cs_n};
      sel_sy <= {sel_sy[SYNC-2:0], preset_sel};
      wr_d   <= wr_sy[SYNC-1];
      cs_d   <= cs_sy[SYNC-1];
    end
  end

  assign wr_s    = wr_sy[SYNC-1];
  assign sel_s   = sel_sy[SYNC-1];
  assign wr_rise = wr_s & ~wr_d & ~cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n)
      dreg_q[NCH] <= '0;
    else if (wr_rise && addr == PRE_ADDR)
      dreg_q[NCH] <= din;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] nxt;

    always_ff @(posedge clk) begin
      if (!rst_n)
        dreg_q[i] <= '0;
      else if (wr_rise && (addr == AW'(i) || addr == BCAST_ADDR))
        dreg_q[i] <= din;
    end

    assign nxt = sel_s ? dreg_q[NCH] : dreg_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_q[i] <= '0;
        upd_q[i]  <= 1'b0;
      end else begin
        code_q[i] <= nxt;
        upd_q[i]  <= (nxt != code_q[i]);
      end
    end

    assign chan_code[i*DW +: DW] = code_q[i];
    assign sense_gnd[i]          = ~clr_n;
  end

  assign upd = upd_q;
endmodule

// File: rtl/quad_dac_frontend_chk.sv
module quad_dac_frontend_chk #(
  parameter int DW  = 14,
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr_n,
  input logic [AW-1:0]         addr,
  input logic [DW-1:0]         din,
  input logic [NCH*DW-1:0]     chan_code,
  input logic [NCH-1:0]        sense_gnd,
  input logic [NCH-1:0]        upd,
  input logic                  wr_rise,
  input logic                  sel_s,
  input logic [NCH:0][DW-1:0]  dreg_q
);
  a_r2_no_write_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(dreg_q)) else $error("R2 register changed without a write edge");

  a_r4_preset_spares_channels: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && addr == AW'(NCH)) |=> $stable(dreg_q[NCH-1:0]))
    else $error("R4 preset write touched a channel register");

  a_r6_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && (addr == AW'(5) || addr == AW'(6))) |=> $stable(dreg_q))
    else $error("R6 unused address changed a register");

  a_r8_flags_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (sense_gnd == '1)) else $error("R8 flags low during clear");

  a_r8_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
    clr_n |-> (sense_gnd == '0)) else $error("R8 flags high without clear");

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r5_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && addr == '1) |=> (dreg_q[i] == $past(din)))
      else $error("R5 broadcast missed a channel");

    a_r7_preset_drives: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> (chan_code[i*DW +: DW] == $past(dreg_q[NCH])))
      else $error("R7 channel not showing preset");

    a_r9_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
      upd[i] |-> (chan_code[i*DW +: DW] != $past(chan_code[i*DW +: DW])))
      else $error("R9 pulse without code change");

    a_r9_change_means_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !upd[i] |-> $stable(chan_code[i*DW +: DW]))
      else $error("R9 code change without pulse");
  end
endmodule

bind quad_dac_frontend quad_dac_frontend_chk #(.DW(DW), .NCH(NCH), .AW(AW)) chk_i (.*);

// File: tb/quad_dac_frontend_tb_top.sv
module quad_dac_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 14;
  localparam int NCH = 4;

  typedef struct { int ch; logic [DW-1:0] code; } item_t;

  logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1, preset_sel = 0, clr_n = 1;
  logic [2:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [NCH*DW-1:0] chan_code;
  logic [NCH-1:0] sense_gnd, upd;

  int checks = 0, errors = 0;
  item_t exp_q[$];
  logic [DW-1:0] mreg [NCH+1];
  logic [DW-1:0] meff [NCH];
  bit msel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .din(din),
    .preset_sel(preset_sel), .clr_n(clr_n), .chan_code(chan_code),
    .sense_gnd(sense_gnd), .upd(upd));

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void refresh();
    for (int i = 0; i < NCH; i++) begin
      logic [DW-1:0] nv;
      nv = msel ? mreg[NCH] : mreg[i];
      if (nv != meff[i]) exp_q.push_back('{ch: i, code: nv});
      meff[i] = nv;
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        if (upd[i]) begin
          if (exp_q.size() == 0) begin
            check(0, "R9", "unexpected pulse on channel", i, -1);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check(it.ch == i, "R9", "pulse channel", i, it.ch);
            check(chan_code[i*DW +: DW] == it.code, "R9", "code at pulse",
                  chan_code[i*DW +: DW], it.code);
          end
        end
      end
    end
  end

  task automatic verify(string req, int wait_cycles);
    repeat (wait_cycles) @(negedge clk);
    check(exp_q.size() == 0, req, "expected pulses outstanding", exp_q.size(), 0);
    exp_q.delete();
    for (int i = 0; i < NCH; i++)
      check(chan_code[i*DW +: DW] == meff[i], req, $sformatf("code ch%0d", i),
            chan_code[i*DW +: DW], meff[i]);
  endtask

  task automatic write_word(logic [2:0] a, logic [DW-1:0] d, bit sel_chip);
    @(negedge clk);
    addr = a; din = d; cs_n = !sel_chip;
    @(negedge clk); wr_n = 0;
    @(negedge clk); @(negedge clk); wr_n = 1;
    if (sel_chip) begin
      if (a < 3'(NCH)) mreg[a] = d;
      else if (a == 3'(NCH)) mreg[NCH] = d;
      else if (a == 3'b111) for (int i = 0; i < NCH; i++) mreg[i] = d;
    end
    refresh();
    @(negedge clk); @(negedge clk); cs_n = 1;
  endtask

  task automatic set_sel(bit v);
    @(negedge clk); preset_sel = v; msel = v; refresh();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i <= NCH; i++) mreg[i] = '0;
    for (int i = 0; i < NCH; i++) meff[i] = '0;
    exp_q.delete();
    rst_n = 1;
  endtask

  initial begin
    for (int i = 0; i <= NCH; i++) mreg[i] = '0;
    for (int i = 0; i < NCH; i++) meff[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(chan_code == '0, "R1", "codes after reset", chan_code, 0);
    check(upd == '0, "R1", "pulses after reset", upd, 0);
    check(sense_gnd == '0, "R1", "flags after reset", sense_gnd, 0);

    // R3 per-channel addressing, bit order
    write_word(3'd0, 14'h2001, 1); verify("R3", 4);
    write_word(3'd1, 14'h1FFF, 1); verify("R3", 4);
    write_word(3'd2, 14'h3FFF, 1); verify("R3", 4);
    write_word(3'd3, 14'h0001, 1); verify("R10", 6);

    // R2 strobe with chip select high
    write_word(3'd0, 14'h0AAA, 0); verify("R2", 6);

    // R6 unused addresses
    write_word(3'd5, 14'h1234, 1); verify("R6", 6);
    write_word(3'd6, 14'h0F0F, 1); verify("R6", 6);

    // R4 preset load, equal to channel B so select leaves B unchanged
    write_word(3'd4, 14'h1FFF, 1); verify("R4", 6);

    // R7 preset override and restore
    set_sel(1); verify("R7", 8);
    write_word(3'd2, 14'h0555, 1); verify("R7", 6);
    write_word(3'd4, 14'h2222, 1); verify("R7", 6);
    set_sel(0); verify("R7", 8);

    // R5 broadcast, matching channel C's current word
    write_word(3'd7, 14'h0555, 1); verify("R5", 6);
    write_word(3'd7, 14'h3C3C, 1); verify("R5", 6);

    // R8 asynchronous clear
    @(negedge clk); #2 clr_n = 0; #1;
    check(sense_gnd == '1, "R8", "flags during clear", sense_gnd, 4'hF);
    write_word(3'd1, 14'h0777, 1); verify("R8", 6);
    check(sense_gnd == '1, "R8", "flags still high", sense_gnd, 4'hF);
    #2 clr_n = 1; #1;
    check(sense_gnd == '0, "R8", "flags after clear", sense_gnd, 0);
    verify("R8", 4);

    // R1 reset mid-run
    do_reset();
    @(negedge clk);
    check(chan_code == '0, "R1", "codes after second reset", chan_code, 0);
    set_sel(1); verify("R1", 8);
    set_sel(0);
    write_word(3'd3, 14'h0100, 1); verify("R3", 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule